// File: doc/BRIEF.md
# TDD Frame Sequencer

This block is the timing core of a time-division-duplex waveform generator. It runs in the interface clock domain and holds a counter that marks the position inside the current frame. When the engine is enabled it captures its configuration and waits for a sync pulse. The sync pulse starts a one-time startup delay. After the delay the engine produces back-to-back frames of a programmed length. It either runs without end or stops after a programmed number of frames.

Per-channel waveform logic downstream compares the frame-relative count against its own on/off offsets. It also uses the one-cycle frame-start strobe to realign. Software reads the two-bit state output to follow the engine's progress. An optional sync-restart mode lets a later sync pulse restart the delay and frame timing while the engine is active.

Top module: `tdd_frame_seq`

## Requirements
- R1: After reset, `state_o` is 0 (idle), `frame_count` is 0 and `frame_start` is 0. The state codes are idle=0, armed=1, waiting=2 (startup delay) and running=3, and `frame_count` is 0 in every state except running.
- R2: In idle, a high `enable` moves the engine to armed on the next cycle and captures `startup_delay`, `frame_length` and `burst_count`. A `sync_pulse` has no effect in idle. Armed is held until a `sync_pulse` arrives.
- R3: A `sync_pulse` seen in armed starts the startup delay. The engine spends exactly D cycles in waiting, where D is the captured `startup_delay`, and then enters running. When D is 0, waiting is skipped and running follows the sync cycle directly.
- R4: In running, `frame_count` counts 0, 1, ..., L-1 and then wraps to 0, where L is the captured `frame_length`. An L of 0 or 1 gives a frame period of one cycle.
- R5: `frame_start` is high for exactly the cycles in which the engine is running and `frame_count` is 0. This includes the first cycle of the first frame.
- R6: A captured `burst_count` of 0 keeps the engine producing frames for as long as `enable` stays high.
- R7: A captured `burst_count` of N greater than 0 makes the engine produce exactly N frames. It then returns to armed with `frame_count` at 0, and the next `sync_pulse` starts a new burst with the same captured settings.
- R8: When `sync_rst_mode` is high, a `sync_pulse` in waiting or running restarts the startup delay, the frame counter and the frame tally of the burst, exactly as a first sync would. When `sync_rst_mode` is low, such a pulse is ignored.
- R9: A low `enable` returns the engine to idle on the next cycle from any state, with `frame_count` at 0.
- R10: Changes to `startup_delay`, `frame_length` or `burst_count` while the engine is out of idle have no effect until the engine next passes from idle to armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enable | input | 1 | Engine enable; low forces idle |
| sync_rst_mode | input | 1 | Lets a sync pulse restart an active engine |
| sync_pulse | input | 1 | Single-cycle sync event |
| startup_delay | input | CNT_W | Cycles spent waiting before the first frame |
| frame_length | input | CNT_W | Frame period in cycles |
| burst_count | input | BURST_W | Frames per burst, 0 for continuous |
| frame_count | output | CNT_W | Position inside the current frame |
| frame_start | output | 1 | High in the first cycle of every frame |
| state_o | output | 2 | Encoded engine state for status readback |

## Verification
The hardest situation to reach from the ports is a sync restart that lands in the middle of a burst. Here the frame tally must be cleared, which is visible only as the burst stopping a full N frames after the restart rather than earlier. The stimulus starts a two-frame burst with sync-restart mode on. It fires a second sync exactly at the start of the second frame and then checks that the engine returns to armed only after two further frames. A restart during the startup delay is reached the same way: a sync is timed partway through the waiting cycles, and the bench checks that the full delay is counted again.

// File: rtl/tdd_seq_pkg.sv
package tdd_seq_pkg;

  typedef enum logic [1:0] {
    TS_IDLE  = 2'd0,
    TS_ARMED = 2'd1,
    TS_WAIT  = 2'd2,
    TS_RUN   = 2'd3
  } tdd_state_e;

endpackage

// File: rtl/tdd_cfg_hold.sv
// Captures the timing configuration when the engine leaves idle and
// precomputes the terminal values that the counters compare against.
module tdd_cfg_hold #(
  parameter int CNT_W   = 16,
  parameter int BURST_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [CNT_W-1:0]   dly_i,
  input  logic [CNT_W-1:0]   len_i,
  input  logic [BURST_W-1:0] burst_i,
  output logic               dly_zero_q,
  output logic [CNT_W-1:0]   dly_last_q,
  output logic [CNT_W-1:0]   len_last_q,
  output logic [BURST_W-1:0] burst_q
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             dly_zero_d;
  logic [CNT_W-1:0] dly_last_d;
  logic [CNT_W-1:0] len_last_d;

  always_comb begin
    dly_zero_d = (dly_i == '0);
    dly_last_d = dly_i - ONE;
    len_last_d = (len_i <= ONE) ? '0 : (len_i - ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_zero_q <= 1'b1;
      dly_last_q <= '0;
      len_last_q <= '0;
      burst_q    <= '0;
    end else if (load) begin
      dly_zero_q <= dly_zero_d;
      dly_last_q <= dly_last_d;
      len_last_q <= len_last_d;
      burst_q    <= burst_i;
    end
  end

endmodule

// File: rtl/tdd_delay_cnt.sv
// Counts the startup-delay cycles while the engine is waiting.
module tdd_delay_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [CNT_W-1:0] last_val,
  output logic             last
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = active ? (cnt_q + ONE) : '0;
    cnt_en = active || (cnt_q != '0);
    last   = (cnt_q == last_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/tdd_frame_cnt.sv
// Frame-relative counter: runs 0..last_val and wraps while active, held at 0 otherwise.
module tdd_frame_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [CNT_W-1:0] last_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             frame_end
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    frame_end = (cnt_q == last_val);
    if (!active)        cnt_d = '0;
    else if (frame_end) cnt_d = '0;
    else                cnt_d = cnt_q + ONE;
    cnt_en = active || (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/tdd_burst_cnt.sv
// Tallies completed frames of a burst; a zero limit never reports the last frame.
module tdd_burst_cnt #(
  parameter int BURST_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               tick,
  input  logic [BURST_W-1:0] limit,
  output logic               last
);

  localparam logic [BURST_W-1:0] ONE = BURST_W'(1);

  logic [BURST_W-1:0] done_q;
  logic [BURST_W-1:0] done_d;
  logic               done_en;

  always_comb begin
    last    = (limit != '0) && (done_q == (limit - ONE));
    done_d  = active ? (done_q + ONE) : '0;
    done_en = (active && tick) || (!active && (done_q != '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= '0;
    end else if (done_en) begin
      done_q <= done_d;
    end
  end

endmodule

// File: rtl/tdd_seq_ctrl.sv
// Engine state machine: next-state logic and state register.
module tdd_seq_ctrl
  import tdd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       sync_pulse,
  input  logic       sync_rst_mode,
  input  logic       dly_zero,
  input  logic       dly_last,
  input  logic       frame_end,
  input  logic       burst_last,
  output tdd_state_e st_q,
  output logic       load_cfg,
  output logic       wait_active,
  output logic       run_active
);

  tdd_state_e st_d;
  logic       restart;

  always_comb begin
    st_d     = st_q;
    restart  = 1'b0;
    load_cfg = 1'b0;
    if (!enable) begin
      st_d = TS_IDLE;
    end else begin
      case (st_q)
        TS_IDLE: begin
          st_d     = TS_ARMED;
          load_cfg = 1'b1;
        end
        TS_ARMED: begin
          if (sync_pulse) restart = 1'b1;
        end
        TS_WAIT: begin
          if (sync_pulse && sync_rst_mode) restart = 1'b1;
          else if (dly_last)               st_d = TS_RUN;
        end
        TS_RUN: begin
          if (sync_pulse && sync_rst_mode)   restart = 1'b1;
          else if (frame_end && burst_last)  st_d = TS_ARMED;
        end
        default: st_d = TS_IDLE;
      endcase
      if (restart) st_d = dly_zero ? TS_RUN : TS_WAIT;
    end
  end

  always_comb begin
    wait_active = enable && !restart && (st_q == TS_WAIT);
    run_active  = enable && !restart && (st_q == TS_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= TS_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

endmodule

// File: rtl/tdd_frame_seq.sv
module tdd_frame_seq
  import tdd_seq_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int BURST_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               sync_rst_mode,
  input  logic               sync_pulse,
  input  logic [CNT_W-1:0]   startup_delay,
  input  logic [CNT_W-1:0]   frame_length,
  input  logic [BURST_W-1:0] burst_count,
  output logic [CNT_W-1:0]   frame_count,
  output logic               frame_start,
  output logic [1:0]         state_o
);

  tdd_state_e         st_q;
  logic               load_cfg;
  logic               wait_active;
  logic               run_active;
  logic               dly_zero_q;
  logic [CNT_W-1:0]   dly_last_q;
  logic [CNT_W-1:0]   len_last_q;
  logic [BURST_W-1:0] burst_q;
  logic               dly_last;
  logic               frame_end;
  logic               burst_last;

  tdd_seq_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .sync_pulse    (sync_pulse),
    .sync_rst_mode (sync_rst_mode),
    .dly_zero      (dly_zero_q),
    .dly_last      (dly_last),
    .frame_end     (frame_end),
    .burst_last    (burst_last),
    .st_q          (st_q),
    .load_cfg      (load_cfg),
    .wait_active   (wait_active),
    .run_active    (run_active)
  );

  tdd_cfg_hold #(.CNT_W(CNT_W), .BURST_W(BURST_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_cfg),
    .dly_i      (startup_delay),
    .len_i      (frame_length),
    .burst_i    (burst_count),
    .dly_zero_q (dly_zero_q),
    .dly_last_q (dly_last_q),
    .len_last_q (len_last_q),
    .burst_q    (burst_q)
  );

  tdd_delay_cnt #(.CNT_W(CNT_W)) u_dly (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (wait_active),
    .last_val (dly_last_q),
    .last     (dly_last)
  );

  tdd_frame_cnt #(.CNT_W(CNT_W)) u_frm (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (run_active),
    .last_val  (len_last_q),
    .cnt_q     (frame_count),
    .frame_end (frame_end)
  );

  tdd_burst_cnt #(.BURST_W(BURST_W)) u_bst (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (run_active),
    .tick   (frame_end),
    .limit  (burst_q),
    .last   (burst_last)
  );

  always_comb begin
    state_o     = st_q;
    frame_start = (st_q == TS_RUN) && (frame_count == '0);
  end

endmodule

// File: rtl/tdd_frame_seq_chk.sv
module tdd_frame_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             sync_pulse,
  input logic             sync_rst_mode,
  input logic [1:0]       state_o,
  input logic [CNT_W-1:0] frame_count,
  input logic [CNT_W-1:0] len_last
);

  p_disable_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (state_o == 2'd0) && (frame_count == '0));

  p_idle_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0) && enable |=> (state_o == 2'd1));

  p_armed_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1) && enable && !sync_pulse |=> (state_o == 2'd1));

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd3) && enable && !(sync_pulse && sync_rst_mode) && (frame_count < len_last)
    |=> frame_count == CNT_W'($past(frame_count) + CNT_W'(1)));

  p_count_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'd3) |-> (frame_count == '0));

  p_wait_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2) && enable |=> (state_o == 2'd2) || (state_o == 2'd3));

  p_run_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd3) && enable && !(sync_pulse && sync_rst_mode)
    |=> (state_o == 2'd3) || (state_o == 2'd1));

endmodule

bind tdd_frame_seq tdd_frame_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .enable        (enable),
  .sync_pulse    (sync_pulse),
  .sync_rst_mode (sync_rst_mode),
  .state_o       (state_o),
  .frame_count   (frame_count),
  .len_last      (len_last_q)
);

// File: tb/tdd_frame_seq_tb.sv
module tdd_frame_seq_tb;

  localparam int CNT_W   = 16;
  localparam int BURST_W = 8;
  localparam int N_VEC   = 19;
  localparam int WDOG    = 100000;

  logic               clk;
  logic               rst_n;
  logic               enable;
  logic               sync_rst_mode;
  logic               sync_pulse;
  logic [CNT_W-1:0]   startup_delay;
  logic [CNT_W-1:0]   frame_length;
  logic [BURST_W-1:0] burst_count;
  logic [CNT_W-1:0]   frame_count;
  logic               frame_start;
  logic [1:0]         state_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  // {enable, sync, expected state[1:0], expected count[7:0], expected start}
  // config D=3, L=4, N=2; row i is checked then its inputs driven at negedge i
  localparam logic [12:0] VEC [N_VEC] = '{
    {1'b1, 1'b0, 2'd0, 8'd0, 1'b0},
    {1'b1, 1'b1, 2'd1, 8'd0, 1'b0},
    {1'b1, 1'b0, 2'd2, 8'd0, 1'b0},
    {1'b1, 1'b0, 2'd2, 8'd0, 1'b0},
    {1'b1, 1'b0, 2'd2, 8'd0, 1'b0},
    {1'b1, 1'b0, 2'd3, 8'd0, 1'b1},
    {1'b1, 1'b0, 2'd3, 8'd1, 1'b0},
    {1'b1, 1'b0, 2'd3, 8'd2, 1'b0},
    {1'b1, 1'b0, 2'd3, 8'd3, 1'b0},
    {1'b1, 1'b0, 2'd3, 8'd0, 1'b1},
    {1'b1, 1'b0, 2'd3, 8'd1, 1'b0},
    {1'b1, 1'b0, 2'd3, 8'd2, 1'b0},
    {1'b1, 1'b0, 2'd3, 8'd3, 1'b0},
    {1'b1, 1'b1, 2'd1, 8'd0, 1'b0},
    {1'b1, 1'b0, 2'd2, 8'd0, 1'b0},
    {1'b1, 1'b0, 2'd2, 8'd0, 1'b0},
    {1'b1, 1'b0, 2'd2, 8'd0, 1'b0},
    {1'b0, 1'b0, 2'd3, 8'd0, 1'b1},
    {1'b0, 1'b0, 2'd0, 8'd0, 1'b0}
  };

  tdd_frame_seq #(.CNT_W(CNT_W), .BURST_W(BURST_W)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .sync_rst_mode (sync_rst_mode),
    .sync_pulse    (sync_pulse),
    .startup_delay (startup_delay),
    .frame_length  (frame_length),
    .burst_count   (burst_count),
    .frame_count   (frame_count),
    .frame_start   (frame_start),
    .state_o       (state_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG) begin
      n_chk = n_chk + 1;
      n_err = n_err + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below %0d", cyc, WDOG);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [1:0] st_e, input int cnt_e, input logic fs_e);
    n_chk = n_chk + 1;
    if (state_o !== st_e || frame_count !== CNT_W'(cnt_e) || frame_start !== fs_e) begin
      n_err = n_err + 1;
      $display("FAIL %s: state=%0d count=%0d start=%0b expected state=%0d count=%0d start=%0b",
               req, state_o, frame_count, frame_start, st_e, cnt_e, fs_e);
    end
  endtask

  task automatic chk_val(input string req, input int act, input int exp_v);
    n_chk = n_chk + 1;
    if (act != exp_v) begin
      n_err = n_err + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // returns at the negedge right after the sync cycle
  task automatic start(input int d, input int l, input int b, input logic mode);
    tick();
    enable = 1'b0; sync_pulse = 1'b0; sync_rst_mode = mode;
    startup_delay = CNT_W'(d); frame_length = CNT_W'(l); burst_count = BURST_W'(b);
    tick();
    enable = 1'b1;
    tick();
    sync_pulse = 1'b1;
    tick();
    sync_pulse = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b0; sync_pulse = 1'b0; sync_rst_mode = 1'b0;
    startup_delay = CNT_W'(3); frame_length = CNT_W'(4); burst_count = BURST_W'(2);
    repeat (3) tick();
    chk("R1 reset state", 2'd0, 0, 1'b0);
    rst_n = 1'b1;

    // R3 R5 R7 table: delay 3, length 4, burst of 2, then re-sync for a new burst
    for (int i = 0; i < N_VEC; i++) begin
      tick();
      chk($sformatf("R3/R5/R7 table row %0d", i), VEC[i][10:9], int'(VEC[i][8:1]), VEC[i][0]);
      enable     = VEC[i][12];
      sync_pulse = VEC[i][11];
    end

    // R2: sync ignored in idle, armed held until sync
    sync_pulse = 1'b1;
    repeat (3) begin tick(); chk("R2 sync ignored in idle", 2'd0, 0, 1'b0); end
    sync_pulse = 1'b0; enable = 1'b1;
    tick(); chk("R2 enable arms", 2'd1, 0, 1'b0);
    repeat (5) tick();
    chk("R2 armed held without sync", 2'd1, 0, 1'b0);

    // R6 continuous with zero delay, R10 config changes ignored while active
    start(0, 3, 0, 1'b0);
    chk("R3 zero delay enters running", 2'd3, 0, 1'b1);
    begin
      int fs_n = 0;
      int bad  = 0;
      for (int k = 1; k <= 60; k++) begin
        tick();
        if (frame_start) fs_n++;
        if (frame_count != CNT_W'(k % 3) || state_o != 2'd3) bad++;
      end
      chk_val("R6 frame starts in continuous run", fs_n, 20);
      chk_val("R4 count sequence mismatches", bad, 0);
      frame_length = CNT_W'(7); burst_count = BURST_W'(1); startup_delay = CNT_W'(5);
      bad = 0;
      for (int k = 61; k <= 90; k++) begin
        tick();
        if (frame_count != CNT_W'(k % 3) || state_o != 2'd3) bad++;
      end
      chk_val("R10 live config change ignored", bad, 0);
    end

    // R9: enable low mid-run
    enable = 1'b0;
    tick(); chk("R9 disable returns to idle", 2'd0, 0, 1'b0);

    // R4: degenerate lengths 1 and 0
    start(0, 1, 0, 1'b0);
    chk("R4 length 1 first", 2'd3, 0, 1'b1);
    repeat (3) begin tick(); chk("R4 length 1 period", 2'd3, 0, 1'b1); end
    start(0, 0, 0, 1'b0);
    repeat (3) begin tick(); chk("R4 length 0 period", 2'd3, 0, 1'b1); end

    // R7: burst of one frame
    start(0, 2, 1, 1'b0);
    chk("R7 single frame c0", 2'd3, 0, 1'b1);
    tick(); chk("R7 single frame c1", 2'd3, 1, 1'b0);
    tick(); chk("R7 single frame stops", 2'd1, 0, 1'b0);

    // R8: restart in running with mode on
    start(0, 8, 0, 1'b1);
    repeat (5) tick();
    chk("R8 before restart", 2'd3, 5, 1'b0);
    sync_pulse = 1'b1;
    tick(); chk("R8 restart in running", 2'd3, 0, 1'b1);
    sync_pulse = 1'b0;
    tick(); chk("R8 after restart", 2'd3, 1, 1'b0);

    // R8: ignored with mode off
    start(0, 8, 0, 1'b0);
    repeat (5) tick();
    sync_pulse = 1'b1;
    tick(); chk("R8 sync ignored mode off", 2'd3, 6, 1'b0);
    sync_pulse = 1'b0;

    // R8: restart during startup delay counts the full delay again
    start(4, 8, 3, 1'b1);
    chk("R3 delay entered", 2'd2, 0, 1'b0);
    tick();
    sync_pulse = 1'b1;
    tick(); sync_pulse = 1'b0;
    repeat (3) tick();
    chk("R8 wait restarted, still waiting", 2'd2, 0, 1'b0);
    tick(); chk("R8 running after full delay", 2'd3, 0, 1'b1);

    // R8: restart mid-burst clears the frame tally
    start(0, 2, 2, 1'b1);
    tick(); tick();
    chk("R8 second frame begins", 2'd3, 0, 1'b1);
    sync_pulse = 1'b1;
    tick(); sync_pulse = 1'b0;
    chk("R8 burst restart", 2'd3, 0, 1'b1);
    tick(); tick();
    chk("R8 tally cleared, still running", 2'd3, 0, 1'b1);
    tick(); tick();
    chk("R7 burst ends after restart", 2'd1, 0, 1'b0);

    enable = 1'b0;
    tick(); chk("R9 final disable", 2'd0, 0, 1'b0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule